// File: doc/BRIEF.md
# Four-Port Registered Bus Exchanger

This block is a clocked crossbar that moves words between four bidirectional ports, here called 1A, 2A, 1B and 2B. Each port appears at the module boundary as three signals: an input word, a registered output word and an output-enable. The enclosing logic, or the pad ring, combines these into a real bus. A 5-bit select code sets up a flow state. The flow state names at most two directed transfers, and each transfer carries one port's word to another port. One clock input serves two purposes, chosen by the level of a select-enable input. With select-enable low, a rising edge loads a new flow state. With select-enable high, a rising edge holds the flow state and latches the source words into the destination output registers.

An active-high preset input turns off every output-enable at once, without waiting for a clock. The outputs come back on only through one clocked step: a rising edge at which preset and select-enable are both low. All bit lanes of a port behave the same way, and the word width is a parameter with a default of 9.

Top module: `bus_exchanger4`

## Requirements
- R1: A rising edge with `sel_en` = 0 and `preset` = 0 loads a new flow state from `sel_code`. From that edge on, `port_oe` shows the destination set of the new state. Port index: 0 = 1A, 1 = 2A, 2 = 1B, 3 = 2B.
- R2: While `sel_en` = 1, the flow state is held. A change on `sel_code` has no effect on `port_oe`. At each rising edge, every enabled destination's `port_out` takes the `port_in` word of its source port.
- R3: When `preset` rises, every bit of `port_oe` goes to 0 with no clock edge.
- R4: After a preset, `port_oe` stays 0 through any edge with `preset` = 1. It also stays 0 through any edge with `sel_en` = 1. It returns only after an edge with `preset` = 0 and `sel_en` = 0.
- R5: Any code with `sel_code[4:3]` = 2'b00 (0x00 to 0x07) loads a state with no port enabled.
- R6: Codes with `sel_code[4:3]` = 2'b01 pair 1A with 2A and 1B with 2B, as follows:
  - 01000: 2A>1A and 1B>2B
  - 01001: 2A>1A
  - 01010: 2B>1B
  - 01011: 2A>1A and 2B>1B
  - 01100: 1A>2A and 1B>2B
  - 01101: 1A>2A
  - 01110: 1B>2B
  - 01111: 1A>2A and 2B>1B
- R7: Codes with `sel_code[4:3]` = 2'b10 pair 1A with 1B and 2A with 2B, as follows:
  - 10000: 1A>1B and 2B>2A
  - 10001: 1A>1B
  - 10010: 2A>2B
  - 10011: 1A>1B and 2A>2B
  - 10100: 1B>1A and 2A>2B
  - 10101: 1B>1A
  - 10110: 2B>2A
  - 10111: 1B>1A and 2B>2A
- R8: Codes with `sel_code[4:3]` = 2'b11 pair 1A with 2B and 1B with 2A, as follows:
  - 11000: 2B>1A and 2A>1B
  - 11001: 1B>2A
  - 11010: 2B>1A
  - 11011: 2B>1A and 1B>2A
  - 11100: 1A>2B and 1B>2A
  - 11101: 1A>2B
  - 11110: 2A>1B
  - 11111: 1A>2B and 2A>1B
- R9: An edge with `sel_en` = 0 latches no data. `port_out` keeps its value even when `port_in` changes.
- R10: While `rst_n` is low, `port_oe` is 0 and `port_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| preset | input | 1 | Asynchronous output kill, active high |
| sel_en | input | 1 | 0: load flow state at the edge; 1: latch data at the edge |
| sel_code | input | 5 | Flow-state select code |
| port_in | input | 4 x W | Word seen on each port (index 0 = 1A, 1 = 2A, 2 = 1B, 3 = 2B) |
| port_out | output | 4 x W | Registered word driven by each port |
| port_oe | output | 4 | Drive enable of each port |

## Verification
The bench loads every one of the 24 two-way codes and sends a distinct word from each port. It then checks both the enable mask and the source that reached each destination. A swapped direction or a wrong pairing therefore shows up as a foreign word or a misplaced enable. The unused codes are loaded to catch a decoder that leaves ports on. A directed preset sequence looks for two faults: an enable that only drops at the next clock edge, and an enable that returns on a data edge or while preset is still high. Two more sequences check the control split. Changing the code with select-enable high must leave the flow in place. Changing the inputs with select-enable low must leave the outputs untouched, which catches a design that latches data on load edges.

// File: rtl/bus_exchanger4_pkg.sv
package bus_exchanger4_pkg;

  localparam int NPORT = 4;
  localparam int SRC_W = $clog2(NPORT);
  localparam int CODE_W = 5;

  typedef enum logic [SRC_W-1:0] {
    P1A = 2'd0,
    P2A = 2'd1,
    P1B = 2'd2,
    P2B = 2'd3
  } port_e;

  typedef struct packed {
    logic [NPORT-1:0]            dst_en;
    logic [NPORT-1:0][SRC_W-1:0] src;
  } flow_t;

  function automatic flow_t xfer(flow_t f, port_e s, port_e d);
    flow_t r;
    r = f;
    r.dst_en[int'(d)] = 1'b1;
    r.src[int'(d)]    = s;
    return r;
  endfunction

  // Decoded flow state: for each destination, an enable and a source index.
  function automatic flow_t decode_flow(logic [CODE_W-1:0] c);
    flow_t f;
    f = '0;
    case (c)
      5'b01000: f = xfer(xfer(f, P2A, P1A), P1B, P2B);
      5'b01001: f = xfer(f, P2A, P1A);
      5'b01010: f = xfer(f, P2B, P1B);
      5'b01011: f = xfer(xfer(f, P2A, P1A), P2B, P1B);
      5'b01100: f = xfer(xfer(f, P1A, P2A), P1B, P2B);
      5'b01101: f = xfer(f, P1A, P2A);
      5'b01110: f = xfer(f, P1B, P2B);
      5'b01111: f = xfer(xfer(f, P1A, P2A), P2B, P1B);
      5'b10000: f = xfer(xfer(f, P1A, P1B), P2B, P2A);
      5'b10001: f = xfer(f, P1A, P1B);
      5'b10010: f = xfer(f, P2A, P2B);
      5'b10011: f = xfer(xfer(f, P1A, P1B), P2A, P2B);
      5'b10100: f = xfer(xfer(f, P1B, P1A), P2A, P2B);
      5'b10101: f = xfer(f, P1B, P1A);
      5'b10110: f = xfer(f, P2B, P2A);
      5'b10111: f = xfer(xfer(f, P1B, P1A), P2B, P2A);
      5'b11000: f = xfer(xfer(f, P2B, P1A), P2A, P1B);
      5'b11001: f = xfer(f, P1B, P2A);
      5'b11010: f = xfer(f, P2B, P1A);
      5'b11011: f = xfer(xfer(f, P2B, P1A), P1B, P2A);
      5'b11100: f = xfer(xfer(f, P1A, P2B), P1B, P2A);
      5'b11101: f = xfer(f, P1A, P2B);
      5'b11110: f = xfer(f, P2A, P1B);
      5'b11111: f = xfer(xfer(f, P1A, P2B), P2A, P1B);
      default:  f = '0;  // all-off code and the unused codes
    endcase
    return f;
  endfunction

endpackage

// File: rtl/bus_exchanger4_flow_ctrl.sv
module bus_exchanger4_flow_ctrl
  import bus_exchanger4_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preset,
  input  logic              sel_en,
  input  logic [CODE_W-1:0] sel_code,
  output flow_t             flow_q,
  output logic              off_q
);

  logic  load;
  flow_t flow_d;
  logic  off_d;

  always_comb begin
    load   = !sel_en && !preset;
    flow_d = load ? decode_flow(sel_code) : flow_q;
    off_d  = load ? 1'b0 : off_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flow_q <= '0;
    else        flow_q <= flow_d;
  end

  // Kill flag: set at once by preset, cleared only by a load edge.
  always_ff @(posedge clk or negedge rst_n or posedge preset) begin
    if (!rst_n)      off_q <= 1'b0;
    else if (preset) off_q <= 1'b1;
    else             off_q <= off_d;
  end

endmodule

// File: rtl/bus_exchanger4_dest_path.sv
module bus_exchanger4_dest_path
  import bus_exchanger4_pkg::*;
#(
  parameter int W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cap_en,
  input  logic                      dst_en,
  input  logic                      off,
  input  logic [SRC_W-1:0]          src_sel,
  input  logic [NPORT-1:0][W-1:0]   bus_in,
  output logic [W-1:0]              data_o,
  output logic                      oe_o
);

  logic [W-1:0] data_q;
  logic [W-1:0] data_d;
  logic         cap;

  always_comb begin
    cap    = cap_en && dst_en;
    data_d = cap ? bus_in[src_sel] : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign data_o = data_q;
  assign oe_o   = dst_en && !off;

endmodule

// File: rtl/bus_exchanger4.sv
module bus_exchanger4
  import bus_exchanger4_pkg::*;
#(
  parameter int W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    preset,
  input  logic                    sel_en,
  input  logic [CODE_W-1:0]       sel_code,
  input  logic [NPORT-1:0][W-1:0] port_in,
  output logic [NPORT-1:0][W-1:0] port_out,
  output logic [NPORT-1:0]        port_oe
);

  flow_t flow_q;
  logic  off_q;

  bus_exchanger4_flow_ctrl u_flow (
    .clk      (clk),
    .rst_n    (rst_n),
    .preset   (preset),
    .sel_en   (sel_en),
    .sel_code (sel_code),
    .flow_q   (flow_q),
    .off_q    (off_q)
  );

  for (genvar d = 0; d < NPORT; d++) begin : g_dest
    bus_exchanger4_dest_path #(.W(W)) u_path (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap_en  (sel_en),
      .dst_en  (flow_q.dst_en[d]),
      .off     (off_q),
      .src_sel (flow_q.src[d]),
      .bus_in  (port_in),
      .data_o  (port_out[d]),
      .oe_o    (port_oe[d])
    );
  end

endmodule

// File: rtl/bus_exchanger4_chk.sv
module bus_exchanger4_chk
  import bus_exchanger4_pkg::*;
#(
  parameter int W = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    preset,
  input logic                    sel_en,
  input logic [CODE_W-1:0]       sel_code,
  input logic [NPORT-1:0][W-1:0] port_out,
  input logic [NPORT-1:0]        port_oe
);

  AST_PRESET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    preset |-> (port_oe == '0)); // R3

  AST_REENABLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((port_oe != '0) && ($past(port_oe) == '0)) |-> $past(!sel_en && !preset)); // R4

  AST_FLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_en && !preset) |=> (preset || $stable(port_oe))); // R2

  AST_UNUSED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_en && !preset && (sel_code < 5'd8)) |=> (port_oe == '0)); // R5

  AST_TWO_DEST_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(port_oe) <= 2)); // R6

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_en |=> $stable(port_out)); // R9

endmodule

bind bus_exchanger4 bus_exchanger4_chk #(.W(W)) chk_i (.*);

// File: tb/bus_exchanger4_tb_top.sv
`timescale 1ns/1ps
module bus_exchanger4_tb_top;

  localparam int W = 9;
  localparam int NP = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic rst_n, preset, sel_en;
  logic [4:0] sel_code;
  logic [NP-1:0][W-1:0] drv, bus, port_out;
  logic [NP-1:0] port_oe;

  // Resolve each bidirectional bus: the exchanger wins when it drives.
  always_comb
    for (int p = 0; p < NP; p++) bus[p] = port_oe[p] ? port_out[p] : drv[p];

  bus_exchanger4 #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .preset(preset), .sel_en(sel_en),
    .sel_code(sel_code), .port_in(bus), .port_out(port_out), .port_oe(port_oe)
  );

  // {code, oe mask [3:0], source of dst3, dst2, dst1, dst0}
  localparam logic [16:0] VEC [24] = '{
    {5'b01000, 4'b1001, 2'd2, 2'd0, 2'd0, 2'd1},
    {5'b01001, 4'b0001, 2'd0, 2'd0, 2'd0, 2'd1},
    {5'b01010, 4'b0100, 2'd0, 2'd3, 2'd0, 2'd0},
    {5'b01011, 4'b0101, 2'd0, 2'd3, 2'd0, 2'd1},
    {5'b01100, 4'b1010, 2'd2, 2'd0, 2'd0, 2'd0},
    {5'b01101, 4'b0010, 2'd0, 2'd0, 2'd0, 2'd0},
    {5'b01110, 4'b1000, 2'd2, 2'd0, 2'd0, 2'd0},
    {5'b01111, 4'b0110, 2'd0, 2'd3, 2'd0, 2'd0},
    {5'b10000, 4'b0110, 2'd0, 2'd0, 2'd3, 2'd0},
    {5'b10001, 4'b0100, 2'd0, 2'd0, 2'd0, 2'd0},
    {5'b10010, 4'b1000, 2'd1, 2'd0, 2'd0, 2'd0},
    {5'b10011, 4'b1100, 2'd1, 2'd0, 2'd0, 2'd0},
    {5'b10100, 4'b1001, 2'd1, 2'd0, 2'd0, 2'd2},
    {5'b10101, 4'b0001, 2'd0, 2'd0, 2'd0, 2'd2},
    {5'b10110, 4'b0010, 2'd0, 2'd0, 2'd3, 2'd0},
    {5'b10111, 4'b0011, 2'd0, 2'd0, 2'd3, 2'd2},
    {5'b11000, 4'b0101, 2'd0, 2'd1, 2'd0, 2'd3},
    {5'b11001, 4'b0010, 2'd0, 2'd0, 2'd2, 2'd0},
    {5'b11010, 4'b0001, 2'd0, 2'd0, 2'd0, 2'd3},
    {5'b11011, 4'b0011, 2'd0, 2'd0, 2'd2, 2'd3},
    {5'b11100, 4'b1010, 2'd0, 2'd0, 2'd2, 2'd0},
    {5'b11101, 4'b1000, 2'd0, 2'd0, 2'd0, 2'd0},
    {5'b11110, 4'b0100, 2'd0, 2'd1, 2'd0, 2'd0},
    {5'b11111, 4'b1100, 2'd0, 2'd1, 2'd0, 2'd0}
  };

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int p, input logic [4:0] c, input logic [1:0] salt);
    return {p[1:0], salt, c};
  endfunction

  task automatic drive_all(input logic [4:0] c, input logic [1:0] salt);
    for (int p = 0; p < NP; p++) drv[p] = pat(p, c, salt);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [4:0] c;
    logic [3:0] m;
    string tag;
    rst_n = 1'b0; preset = 1'b0; sel_en = 1'b1; sel_code = '0; drv = '0;
    repeat (3) @(negedge clk);
    chk("R10 oe in reset", port_oe, 4'b0);
    chk("R10 out in reset", port_out, '0);
    rst_n = 1'b1;

    // Unused and all-off codes
    for (int k = 0; k < 8; k++) begin
      sel_en = 1'b0; sel_code = 5'(k); drive_all(5'(k), 2'b01);
      @(negedge clk);
      chk("R5 oe after unused code", port_oe, 4'b0);
      sel_en = 1'b1;
      @(negedge clk);
      chk("R5 oe after data edge", port_oe, 4'b0);
    end

    // Every two-way code
    for (int i = 0; i < 24; i++) begin
      c = VEC[i][16:12]; m = VEC[i][11:8];
      tag = (c[4:3] == 2'b01) ? "R6" : (c[4:3] == 2'b10) ? "R7" : "R8";
      sel_en = 1'b0; sel_code = c; drive_all(c, 2'b10);
      @(negedge clk);
      chk({"R1 ", tag, " oe mask"}, port_oe, m);
      sel_en = 1'b1;
      @(negedge clk);
      chk({"R2 ", tag, " oe held"}, port_oe, m);
      for (int d = 0; d < NP; d++)
        if (m[d]) chk({"R2 ", tag, " routed word"}, port_out[d], drv[VEC[i][2*d +: 2]]);
    end

    // R2: code change ignored while sel_en high; capture continues
    sel_en = 1'b0; sel_code = 5'b01100; drive_all(5'b01100, 2'b00);
    @(negedge clk);
    sel_en = 1'b1; sel_code = 5'b10000; drive_all(5'b00011, 2'b11);
    @(negedge clk);
    chk("R2 oe held despite code change", port_oe, 4'b1010);
    chk("R2 2A takes 1A", port_out[1], drv[0]);
    chk("R2 2B takes 1B", port_out[3], drv[2]);

    // R9: load edge latches no data
    sel_en = 1'b0; sel_code = 5'b01100; drive_all(5'b00101, 2'b01);
    @(negedge clk);
    chk("R9 2A held", port_out[1], pat(0, 5'b00011, 2'b11));
    chk("R9 2B held", port_out[3], pat(2, 5'b00011, 2'b11));

    // R3/R4: preset kill and recovery
    #1 preset = 1'b1;
    #0.5 chk("R3 oe off without clock", port_oe, 4'b0);
    @(negedge clk);
    chk("R4 off while preset high", port_oe, 4'b0);
    preset = 1'b0; sel_en = 1'b1;
    @(negedge clk);
    chk("R4 off after data edge", port_oe, 4'b0);
    sel_en = 1'b0; sel_code = 5'b01100;
    @(negedge clk);
    chk("R4 back on after load edge", port_oe, 4'b1010);

    finish_run();
  end

endmodule